// File: doc/BRIEF.md
# Rename Map With Committed Bits

This block keeps, for each architectural register, a record of where its newest value will come from. An entry either says that the value is already committed in the retirement register file, or it names the reorder-buffer slot that will produce it. Each cycle the front end offers a group of up to `LANES` micro-operations in program order. For each one the block returns where its two sources come from, and it records any destinations that the group writes. Reorder-buffer slot numbers are allocated elsewhere and arrive as inputs.

Source lookups are combinational. A source that names a register written by an earlier lane of the same group receives that lane's new slot number, not the table contents. Table updates take effect at the next clock edge.

Retirement reports a register together with the slot that produced it. The committed bit comes back only when the table still points at that exact slot. Recovery marks every register committed in one cycle.

Top module: `alias_map`

## Requirements
- R1: After reset every register reads as committed (`*_ret` = 1).
- R2: A source output gives the committed bit of the named register. When that bit is 0, the tag output is the reorder-buffer slot it waits on. When the bit is 1, the tag output has no meaning.
- R3: A lane with `dst_we` high writes `dst_tag` for `dst_reg`. From the next cycle on, that register reads as pending (bit 0) with that tag.
- R4: A source in lane i that names a register written by an earlier lane j<i of the same group reads bit 0 and the tag of the latest such lane, in the same cycle.
- R5: A lane's own destination and any destination of a later lane do not affect that lane's source lookups.
- R6: When several lanes of one group write the same register, the highest-numbered lane's tag is the one stored.
- R7: A retirement (`ret_vld`, `ret_reg`, `ret_tag`) whose tag equals the register's stored tag makes that register read committed from the next cycle on.
- R8: A retirement whose tag differs from the stored tag leaves the register pending with its stored tag.
- R9: When a register is renamed and retired in the same cycle, the rename wins and the register reads pending with the new tag.
- R10: `recover` makes every register read committed from the next cycle on. This holds even for registers renamed in that same cycle.
- R11: A lane with `dst_we` low neither writes the table nor forwards its destination to later lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover | input | 1 | Mark all registers committed |
| dst_we | input | LANES | Per-lane destination write enable |
| dst_reg | input | LANES x AW | Per-lane destination register |
| dst_tag | input | LANES x TAG_W | Per-lane newly allocated slot |
| src0_reg | input | LANES x AW | Per-lane first source register |
| src1_reg | input | LANES x AW | Per-lane second source register |
| ret_vld | input | RLANES | Per-retire-lane valid |
| ret_reg | input | RLANES x AW | Retiring destination register |
| ret_tag | input | RLANES x TAG_W | Slot of the retiring micro-operation |
| src0_ret | output | LANES | First source is committed |
| src0_tag | output | LANES x TAG_W | First source slot when pending |
| src1_ret | output | LANES | Second source is committed |
| src1_tag | output | LANES x TAG_W | Second source slot when pending |

## Verification
The bench uses the default parameters: three rename lanes, three retire lanes, eight architectural registers and 5-bit slot numbers. Eight registers shared by three lanes make same-group collisions common, both destination-on-source and destination-on-destination. Sharing the retire lanes across the same small set makes rename-versus-retire clashes and stale retirements common too. A directed phase covers each corner first. A random phase then mixes recoveries with retirements, half of which carry the currently stored tag.

// File: rtl/alias_map.sv
module alias_map #(
  parameter int LANES  = 3,
  parameter int AREGS  = 8,
  parameter int TAG_W  = 5,
  parameter int RLANES = 3,
  localparam int AW    = $clog2(AREGS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          recover,
  input  logic [LANES-1:0]              dst_we,
  input  logic [LANES-1:0][AW-1:0]      dst_reg,
  input  logic [LANES-1:0][TAG_W-1:0]   dst_tag,
  input  logic [LANES-1:0][AW-1:0]      src0_reg,
  input  logic [LANES-1:0][AW-1:0]      src1_reg,
  input  logic [RLANES-1:0]             ret_vld,
  input  logic [RLANES-1:0][AW-1:0]     ret_reg,
  input  logic [RLANES-1:0][TAG_W-1:0]  ret_tag,
  output logic [LANES-1:0]              src0_ret,
  output logic [LANES-1:0][TAG_W-1:0]   src0_tag,
  output logic [LANES-1:0]              src1_ret,
  output logic [LANES-1:0][TAG_W-1:0]   src1_tag
);

  logic [AREGS-1:0]             tbl_ret, nxt_ret;
  logic [AREGS-1:0][TAG_W-1:0]  tbl_tag, nxt_tag;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      src0_ret[i] = tbl_ret[src0_reg[i]];
      src0_tag[i] = tbl_tag[src0_reg[i]];
      src1_ret[i] = tbl_ret[src1_reg[i]];
      src1_tag[i] = tbl_tag[src1_reg[i]];
      for (int j = 0; j < i; j++) begin
        if (dst_we[j] && dst_reg[j] == src0_reg[i]) begin
          src0_ret[i] = 1'b0;
          src0_tag[i] = dst_tag[j];
        end
        if (dst_we[j] && dst_reg[j] == src1_reg[i]) begin
          src1_ret[i] = 1'b0;
          src1_tag[i] = dst_tag[j];
        end
      end
    end
  end

  always_comb begin
    nxt_ret = tbl_ret;
    nxt_tag = tbl_tag;
    for (int k = 0; k < RLANES; k++)
      if (ret_vld[k] && tbl_tag[ret_reg[k]] == ret_tag[k])
        nxt_ret[ret_reg[k]] = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (dst_we[i]) begin
        nxt_ret[dst_reg[i]] = 1'b0;
        nxt_tag[dst_reg[i]] = dst_tag[i];
      end
    if (recover) nxt_ret = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_ret <= '1;
      tbl_tag <= '0;
    end else begin
      tbl_ret <= nxt_ret;
      tbl_tag <= nxt_tag;
    end
  end

endmodule

// File: rtl/alias_map_chk.sv
module alias_map_chk #(
  parameter int LANES  = 3,
  parameter int AREGS  = 8,
  parameter int TAG_W  = 5,
  parameter int RLANES = 3,
  localparam int AW    = $clog2(AREGS)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          recover,
  input logic [LANES-1:0]              dst_we,
  input logic [LANES-1:0][AW-1:0]      dst_reg,
  input logic [LANES-1:0][TAG_W-1:0]   dst_tag,
  input logic [LANES-1:0][AW-1:0]      src0_reg,
  input logic [LANES-1:0]              src0_ret,
  input logic [LANES-1:0][TAG_W-1:0]   src0_tag,
  input logic [RLANES-1:0]             ret_vld,
  input logic [RLANES-1:0][AW-1:0]     ret_reg,
  input logic [AREGS-1:0]              tbl_ret,
  input logic [AREGS-1:0][TAG_W-1:0]   tbl_tag
);

  logic [AREGS-1:0] wr_hit, rt_hit;

  always_comb begin
    wr_hit = '0;
    rt_hit = '0;
    for (int i = 0; i < LANES; i++)
      if (dst_we[i]) wr_hit[dst_reg[i]] = 1'b1;
    for (int k = 0; k < RLANES; k++)
      if (ret_vld[k]) rt_hit[ret_reg[k]] = 1'b1;
  end

  a_r10_recover_all: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> &tbl_ret);

  a_r3_last_lane_written: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we[LANES-1] && !recover |=>
      !tbl_ret[$past(dst_reg[LANES-1])] &&
      tbl_tag[$past(dst_reg[LANES-1])] == $past(dst_tag[LANES-1]));

  for (genvar r = 0; r < AREGS; r++) begin : g_reg
    a_r9_rename_pends: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[r] && !recover |=> !tbl_ret[r]);
    a_r8_no_spurious_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !tbl_ret[r] && !rt_hit[r] && !recover |=> !tbl_ret[r]);
  end

  if (LANES >= 2) begin : g_byp
    a_r4_lane1_forward: assert property (@(posedge clk) disable iff (!rst_n)
      dst_we[0] && src0_reg[1] == dst_reg[0] |->
        !src0_ret[1] && src0_tag[1] == dst_tag[0]);
  end

endmodule

bind alias_map alias_map_chk #(
  .LANES(LANES), .AREGS(AREGS), .TAG_W(TAG_W), .RLANES(RLANES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .recover(recover),
  .dst_we(dst_we), .dst_reg(dst_reg), .dst_tag(dst_tag),
  .src0_reg(src0_reg), .src0_ret(src0_ret), .src0_tag(src0_tag),
  .ret_vld(ret_vld), .ret_reg(ret_reg),
  .tbl_ret(tbl_ret), .tbl_tag(tbl_tag)
);

// File: tb/alias_map_tb_top.sv
module alias_map_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 3, AREGS = 8, TAG_W = 5, RLANES = 3;
  localparam int AW = $clog2(AREGS);

  logic clk = 1'b0, rst_n = 1'b0, recover = 1'b0;
  logic [LANES-1:0] dst_we = '0;
  logic [LANES-1:0][AW-1:0] dst_reg = '0, src0_reg = '0, src1_reg = '0;
  logic [LANES-1:0][TAG_W-1:0] dst_tag = '0;
  logic [RLANES-1:0] ret_vld = '0;
  logic [RLANES-1:0][AW-1:0] ret_reg = '0;
  logic [RLANES-1:0][TAG_W-1:0] ret_tag = '0;
  logic [LANES-1:0] src0_ret, src1_ret;
  logic [LANES-1:0][TAG_W-1:0] src0_tag, src1_tag;

  alias_map #(.LANES(LANES), .AREGS(AREGS), .TAG_W(TAG_W), .RLANES(RLANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .recover(recover),
    .dst_we(dst_we), .dst_reg(dst_reg), .dst_tag(dst_tag),
    .src0_reg(src0_reg), .src1_reg(src1_reg),
    .ret_vld(ret_vld), .ret_reg(ret_reg), .ret_tag(ret_tag),
    .src0_ret(src0_ret), .src0_tag(src0_tag),
    .src1_ret(src1_ret), .src1_tag(src1_tag));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [LANES-1:0] r0, r1;
    logic [LANES-1:0][TAG_W-1:0] t0, t1;
    string req;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit m_ret [AREGS];
  logic [TAG_W-1:0] m_tag [AREGS];

  task automatic look(input logic [AW-1:0] s, input int lane, output logic r, output logic [TAG_W-1:0] t);
    r = m_ret[s];
    t = m_tag[s];
    for (int j = lane - 1; j >= 0; j--)
      if (dst_we[j] && dst_reg[j] == s) begin
        r = 1'b0;
        t = dst_tag[j];
        break;
      end
  endtask

  task automatic run_cycle(input string req);
    exp_t e;
    bit n_ret [AREGS];
    logic [TAG_W-1:0] n_tag [AREGS];
    for (int i = 0; i < LANES; i++) begin
      look(src0_reg[i], i, e.r0[i], e.t0[i]);
      look(src1_reg[i], i, e.r1[i], e.t1[i]);
    end
    e.req = req;
    q.push_back(e);
    n_ret = m_ret;
    n_tag = m_tag;
    for (int k = 0; k < RLANES; k++)
      if (ret_vld[k] && m_tag[ret_reg[k]] == ret_tag[k]) n_ret[ret_reg[k]] = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (dst_we[i]) begin
        n_ret[dst_reg[i]] = 1'b0;
        n_tag[dst_reg[i]] = dst_tag[i];
      end
    if (recover)
      for (int r = 0; r < AREGS; r++) n_ret[r] = 1'b1;
    @(posedge clk);
    m_ret = n_ret;
    m_tag = n_tag;
    #1;
  endtask

  task automatic idle();
    dst_we = '0; ret_vld = '0; recover = 1'b0;
  endtask

  task automatic cmp(input string req, input string what, input logic ar, input logic [TAG_W-1:0] at,
                     input logic er, input logic [TAG_W-1:0] et);
    total++;
    if (ar !== er || (er == 1'b0 && at !== et)) begin
      bad++;
      $display("FAIL %s %s: got ret=%0b tag=%0d, expected ret=%0b tag=%0d", req, what, ar, at, er, et);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      for (int i = 0; i < LANES; i++) begin
        cmp(e.req, $sformatf("lane%0d src0", i), src0_ret[i], src0_tag[i], e.r0[i], e.t0[i]);
        cmp(e.req, $sformatf("lane%0d src1", i), src1_ret[i], src1_tag[i], e.r1[i], e.t1[i]);
      end
    end
  end

  task automatic read_regs(input string req, input int base);
    idle();
    for (int i = 0; i < LANES; i++) begin
      src0_reg[i] = AW'((base + 2 * i) % AREGS);
      src1_reg[i] = AW'((base + 2 * i + 1) % AREGS);
    end
    run_cycle(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < AREGS; r++) begin m_ret[r] = 1'b1; m_tag[r] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    read_regs("R1 reset", 0);
    read_regs("R1 reset", 6);

    // R3 R4 R5: lane0 writes r3, lane2 writes r5; lane1 reads r3 (forward), lane0 reads r5 (table)
    idle();
    dst_we = 3'b101;
    dst_reg[0] = 3; dst_tag[0] = 7;
    dst_reg[2] = 5; dst_tag[2] = 9;
    src0_reg[0] = 5; src1_reg[0] = 3;
    src0_reg[1] = 3; src1_reg[1] = 5;
    src0_reg[2] = 3; src1_reg[2] = 5;
    run_cycle("R4 R5 same-group forward");
    read_regs("R3 rename recorded", 3);

    // R6: lanes 0 and 2 both write r1
    idle();
    dst_we = 3'b101;
    dst_reg[0] = 1; dst_tag[0] = 10;
    dst_reg[2] = 1; dst_tag[2] = 11;
    src0_reg[1] = 1; src1_reg[1] = 1; src0_reg[2] = 1; src1_reg[2] = 0;
    src0_reg[0] = 1; src1_reg[0] = 2;
    run_cycle("R6 R4 double write");
    read_regs("R6 later lane wins", 1);

    // R5: lane1 reads the register it writes itself
    idle();
    dst_we = 3'b010; dst_reg[1] = 2; dst_tag[1] = 12;
    src0_reg[1] = 2; src1_reg[1] = 2;
    run_cycle("R5 own destination");

    // R11: disabled lane neither writes nor forwards
    idle();
    dst_reg[0] = 4; dst_tag[0] = 13;
    src0_reg[1] = 4; src1_reg[2] = 4;
    run_cycle("R11 no write enable");
    read_regs("R11 table untouched", 4);

    // R7: matching retire of r3 tag 7
    idle();
    ret_vld = 3'b001; ret_reg[0] = 3; ret_tag[0] = 7;
    run_cycle("R7 retire match");
    read_regs("R7 committed", 3);

    // R8: stale retire of r5 (stored 9)
    idle();
    ret_vld = 3'b100; ret_reg[2] = 5; ret_tag[2] = 3;
    run_cycle("R8 stale retire");
    read_regs("R8 still pending", 5);

    // R9: rename and retire r5 in the same cycle
    idle();
    ret_vld = 3'b010; ret_reg[1] = 5; ret_tag[1] = 9;
    dst_we = 3'b001; dst_reg[0] = 5; dst_tag[0] = 14;
    run_cycle("R9 rename beats retire");
    read_regs("R9 pending new tag", 5);

    // R10: recover alongside a rename
    idle();
    recover = 1'b1;
    dst_we = 3'b001; dst_reg[0] = 6; dst_tag[0] = 15;
    run_cycle("R10 recover");
    read_regs("R10 all committed", 0);
    read_regs("R10 all committed", 6);

    // Random mix: R2 R3 R4 R6 R7 R8 R9 R10
    for (int n = 0; n < 400; n++) begin
      idle();
      for (int i = 0; i < LANES; i++) begin
        dst_we[i] = 1'($urandom_range(1));
        dst_reg[i] = AW'($urandom_range(AREGS - 1));
        dst_tag[i] = TAG_W'($urandom);
        src0_reg[i] = AW'($urandom_range(AREGS - 1));
        src1_reg[i] = AW'($urandom_range(AREGS - 1));
      end
      for (int k = 0; k < RLANES; k++) begin
        ret_vld[k] = 1'($urandom_range(1));
        ret_reg[k] = AW'($urandom_range(AREGS - 1));
        ret_tag[k] = $urandom_range(1) ? m_tag[ret_reg[k]] : TAG_W'($urandom);
      end
      recover = ($urandom_range(19) == 0);
      run_cycle("R2 random mix");
    end

    idle();
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule